// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Interface

This block is a single-byte SPI master. A processor controls it through a small register file on an 8-bit bus. Each write to the data register, made while the controller is enabled in master mode, shifts one byte out on MOSI and captures one byte from MISO at the same time. A control register sets the clock polarity, the clock phase and the bit order. A baud register divides the bus clock: the SCK period is (prescaler + 1) × 2^(exponent + 1) bus cycles.

Three sticky status flags are provided. The done flag marks the end of a byte. The collision flag marks a data write that arrived while a byte was still shifting; that byte is discarded, not queued. The fault flag marks another device pulling the select line low while this master is active. Software clears the flags by reading the status register and then the data register. Each of two interrupt lines follows one flag, and both are gated by the interrupt-enable bit. A port register and a direction register set the slave-select output level and the pin output enables.

The bus is a plain single-cycle register port. Reads return data combinationally on `bus_rdata` in the cycle `bus_sel` is high. Writes and read side effects take place at that clock edge. The port has no wait states and no back-pressure.

Top module: `spim_ctrl`

## Requirements
- R1: Register offsets are: control at 0x00, auxiliary control at 0x01, baud at 0x04, status at 0x05, data at 0x09, port at 0x0D, direction at 0x10. Control, auxiliary, port and direction read back the last byte written. Baud reads back only bits 6:4 (prescaler) and bits 2:0 (exponent), with the other bits reading 0. `pin_oe_o[2:0]` equals direction bits 3:1 (SCK, MOSI, select).
- R2: A data write shifts the byte out on MOSI and captures 8 MISO bits when control bit 6 (enable) and bit 4 (master) are both 1 and no byte is shifting. A later data read returns the captured byte.
- R3: With baud prescaler P and exponent E, the done flag is set exactly 16·(P+1)·2^E bus cycles after the clock edge that takes the data write.
- R4: When idle, SCK rests at control bit 3 (CPOL). With control bit 2 (CPHA) at 0, the first bit is on MOSI before the first SCK edge and MISO is sampled on the odd edges. With CPHA at 1, data changes on the odd edges and is sampled on the even edges.
- R5: With control bit 0 set, bit 0 of the byte goes first in both directions. Otherwise bit 7 goes first.
- R6: Status bit 7 is set when a byte completes. `irq_done_o` is high when that flag and control bit 7 are both set.
- R7: A data write while a byte is shifting sets status bit 6. The write is dropped and the byte in flight is unaffected.
- R8: Flags are cleared only by a status read followed by a data read. Only the flags seen set at that status read are cleared. A data read with no status read first clears nothing.
- R9: When direction bit 3 is 0, and enable and master are set, a low `ss_n_i` sets status bit 4. It also clears control bits 6 and 4, stops any shift with SCK returned to idle, and raises `irq_fault_o` if control bit 7 is set.
- R10: `ss_n_o` follows port bit 3. If control bit 1 is set together with enable and master, it is instead driven low while a byte is shifting and high otherwise.
- R11: A data write while enable or master is 0 starts no shift and sets no flag.
- R12: After reset all registers read 0 except the port register, which reads 0x08. SCK is low, `ss_n_o` is high, both interrupt lines are low and `pin_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Slave-select output, active low |
| ss_n_i | input | 1 | Slave-select sense input for fault detection |
| pin_oe_o | output | 3 | Output enables for SCK, MOSI, select |
| irq_done_o | output | 1 | Byte-done interrupt |
| irq_fault_o | output | 1 | Mode-fault interrupt |

## Verification
The assertions assume that `ss_n_i` and `miso_i` are already synchronous to `clk`. They also assume that the baud and control fields stay fixed while a byte is shifting, so the tick spacing and SCK hold checks only see steady divisors. The stimulus writes the mode and baud registers only while the shifter is idle. The bench slave changes MISO only on the SCK edges where the master does not sample, and pulls `ss_n_i` low only in the fault tests.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_AUX  = 'h01;
  localparam int OFS_BAUD = 'h04;
  localparam int OFS_STAT = 'h05;
  localparam int OFS_DATA = 'h09;
  localparam int OFS_PORT = 'h0D;
  localparam int OFS_DIR  = 'h10;

  // control bit positions
  localparam int CB_IE    = 7;
  localparam int CB_EN    = 6;
  localparam int CB_MSTR  = 4;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 2;
  localparam int CB_AUTO  = 1;
  localparam int CB_LSB   = 0;

  // status bit positions
  localparam int SB_DONE  = 7;
  localparam int SB_COLL  = 6;
  localparam int SB_FAULT = 4;

  // port / direction bit for the select line
  localparam int PB_SEL   = 3;

  typedef struct packed {
    logic done;
    logic coll;
    logic fault;
  } spim_flags_t;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;

  // half SCK period in bus cycles: (pre + 1) * 2^expo
  assign half = (CNT_W'(pre) + CNT_W'(1)) << expo;
  assign tick = run && !restart && (cnt >= half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart || !run || tick)  cnt <= '0;
    else                               cnt <= cnt + CNT_W'(1);
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (half > CNT_W'(1)) |=> !tick);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic [W-1:0] tx_byte,
  input  logic         miso,
  output logic         busy,
  output logic         sck_ph,
  output logic         mosi,
  output logic         last,
  output logic [W-1:0] rx_next
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0] edge_q;
  logic [W-1:0]  tx_sr, rx_sr;
  logic          busy_q, ph_q;
  logic          sample_e, shift_e;

  assign sample_e = cpha ? edge_q[0] : !edge_q[0];
  assign shift_e  = cpha ? (!edge_q[0] && (edge_q != '0)) : edge_q[0];
  assign last     = busy_q && tick && (edge_q == EW'(EDGES - 1));
  assign busy     = busy_q;
  assign sck_ph   = ph_q;
  assign mosi     = lsb_first ? tx_sr[0] : tx_sr[W-1];

  always_comb begin
    rx_next = rx_sr;
    if (busy_q && tick && sample_e)
      rx_next = lsb_first ? {miso, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      edge_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      edge_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      edge_q <= '0;
      tx_sr  <= tx_byte;
    end else if (busy_q && tick) begin
      ph_q   <= !ph_q;
      edge_q <= edge_q + EW'(1);
      rx_sr  <= rx_next;
      if (shift_e)
        tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (last)
        busy_q <= 1'b0;
    end
  end

  // R4
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick && !abort |=> $stable(ph_q));
  // R4
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 8,
  parameter int PRE_W  = 3,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_n_o,
  input  logic              ss_n_i,
  output logic [2:0]        pin_oe_o,
  output logic              irq_done_o,
  output logic              irq_fault_o
);
  localparam int EXP_LO = 0;
  localparam int PRE_LO = 4;

  logic [DW-1:0]    ctrl_q, aux_q, port_q, dir_q, rx_q;
  logic [PRE_W-1:0] pre_q;
  logic [EXP_W-1:0] exp_q;
  spim_flags_t      flags_q, snap_q;
  logic             arm_q;

  logic wr_acc, rd_acc, data_wr, data_rd, stat_rd;
  logic enabled, fault, start, coll, clear;
  logic busy, sck_ph, last, tick;
  logic [DW-1:0] rx_next;

  assign wr_acc  = bus_sel && bus_wr;
  assign rd_acc  = bus_sel && !bus_wr;
  assign data_wr = wr_acc && (bus_addr == ADDR_W'(OFS_DATA));
  assign data_rd = rd_acc && (bus_addr == ADDR_W'(OFS_DATA));
  assign stat_rd = rd_acc && (bus_addr == ADDR_W'(OFS_STAT));

  assign enabled = ctrl_q[CB_EN] && ctrl_q[CB_MSTR];
  assign fault   = enabled && !dir_q[PB_SEL] && !ss_n_i;
  assign start   = data_wr && enabled && !busy && !fault;
  assign coll    = data_wr && busy;
  assign clear   = data_rd && arm_q;

  spim_clkdiv #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
    .pre(pre_q), .expo(exp_q), .tick(tick)
  );

  spim_shift #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(fault), .tick(tick),
    .cpha(ctrl_q[CB_CPHA]), .lsb_first(ctrl_q[CB_LSB]), .tx_byte(bus_wdata),
    .miso(miso_i), .busy(busy), .sck_ph(sck_ph), .mosi(mosi_o),
    .last(last), .rx_next(rx_next)
  );

  assign sck_o       = ctrl_q[CB_CPOL] ^ sck_ph;
  assign ss_n_o      = (ctrl_q[CB_AUTO] && enabled) ? !busy : port_q[PB_SEL];
  assign pin_oe_o    = dir_q[3:1];
  assign irq_done_o  = ctrl_q[CB_IE] && flags_q.done;
  assign irq_fault_o = ctrl_q[CB_IE] && flags_q.fault;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      port_q <= DW'(8'h08);
      dir_q  <= '0;
      pre_q  <= '0;
      exp_q  <= '0;
      rx_q   <= '0;
    end else begin
      if (fault) begin
        ctrl_q[CB_EN]   <= 1'b0;
        ctrl_q[CB_MSTR] <= 1'b0;
      end else if (wr_acc && bus_addr == ADDR_W'(OFS_CTRL)) begin
        ctrl_q <= bus_wdata;
      end
      if (wr_acc && bus_addr == ADDR_W'(OFS_AUX))  aux_q  <= bus_wdata;
      if (wr_acc && bus_addr == ADDR_W'(OFS_PORT)) port_q <= bus_wdata;
      if (wr_acc && bus_addr == ADDR_W'(OFS_DIR))  dir_q  <= bus_wdata;
      if (wr_acc && bus_addr == ADDR_W'(OFS_BAUD)) begin
        pre_q <= bus_wdata[PRE_LO +: PRE_W];
        exp_q <= bus_wdata[EXP_LO +: EXP_W];
      end
      if (last) rx_q <= rx_next;
    end
  end

  // sticky flags with status-then-data clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      snap_q  <= '0;
      arm_q   <= 1'b0;
    end else begin
      if (last)                         flags_q.done  <= 1'b1;
      else if (clear && snap_q.done)    flags_q.done  <= 1'b0;
      if (coll)                         flags_q.coll  <= 1'b1;
      else if (clear && snap_q.coll)    flags_q.coll  <= 1'b0;
      if (fault)                        flags_q.fault <= 1'b1;
      else if (clear && snap_q.fault)   flags_q.fault <= 1'b0;
      if (stat_rd) begin
        snap_q <= flags_q;
        arm_q  <= |flags_q;
      end else if (clear) begin
        arm_q  <= 1'b0;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_AUX:  bus_rdata = aux_q;
      OFS_BAUD: begin
        bus_rdata[PRE_LO +: PRE_W] = pre_q;
        bus_rdata[EXP_LO +: EXP_W] = exp_q;
      end
      OFS_STAT: begin
        bus_rdata[SB_DONE]  = flags_q.done;
        bus_rdata[SB_COLL]  = flags_q.coll;
        bus_rdata[SB_FAULT] = flags_q.fault;
      end
      OFS_DATA: bus_rdata = rx_q;
      OFS_PORT: bus_rdata = port_q;
      OFS_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R6
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.done) |-> $past(busy));
  // R7
  coll_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.coll) |-> $past(busy));
  // R9
  fault_drops_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.fault) |-> !ctrl_q[CB_EN] && !ctrl_q[CB_MSTR] && !busy);
  // R8
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q.done) |-> $past(arm_q) && $past(data_rd));
  // R11
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enabled));
endmodule

// File: tb/spim_ctrl_tb_top.sv
`timescale 1ns/1ps
module spim_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sck_o, mosi_o, miso_i, ss_n_o;
  logic       ss_n_i = 1'b1;
  logic [2:0] pin_oe_o;
  logic       irq_done_o, irq_fault_o;

  int total = 0, bad = 0;

  always #5 clk = !clk;

  spim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o),
    .ss_n_i(ss_n_i), .pin_oe_o(pin_oe_o), .irq_done_o(irq_done_o),
    .irq_fault_o(irq_fault_o)
  );

  // bench slave: drives MISO, captures MOSI, per mode
  logic [7:0] slv_byte = '0, cap = '0;
  int  slv_idx = 0, cap_idx = 0, chg_cnt = 0;
  bit  mon = 0, m_cpol = 0, m_cpha = 0, m_lsb = 0;

  function automatic logic pick(input logic [7:0] b, input int k, input bit lsb);
    int j;
    j = (k > 7) ? 7 : k;
    return lsb ? b[j] : b[7-j];
  endfunction

  assign miso_i = pick(slv_byte, slv_idx, m_lsb);

  always @(sck_o) begin
    if (mon && rst_n) begin
      automatic bit lead = (sck_o != m_cpol);
      if (lead != m_cpha) begin
        if (cap_idx < 8) cap[m_lsb ? cap_idx : 7 - cap_idx] = mosi_o;
        cap_idx++;
      end else begin
        if (!m_cpha || chg_cnt > 0) slv_idx++;
        chg_cnt++;
      end
    end
  end

  task automatic slave_arm(input bit cp, input bit ph, input bit lsb, input logic [7:0] sb);
    m_cpol = cp; m_cpha = ph; m_lsb = lsb; slv_byte = sb;
    cap = '0; slv_idx = 0; cap_idx = 0; chg_cnt = 0; mon = 1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!irq_done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {mode[2:0]=cpol,cpha,lsb, baud, tx, slave}
  localparam logic [31:0] VEC [0:5] = '{
    32'h00_00_A5_3C, 32'h01_10_81_7E, 32'h02_01_C3_96,
    32'h04_21_5A_E1, 32'h07_32_0F_F0, 32'h06_77_69_12
  };

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    rd(5'h00, d); chk(d == 8'h00, "R12 ctrl", d, 0);
    rd(5'h05, d); chk(d == 8'h00, "R12 status", d, 0);
    rd(5'h0D, d); chk(d == 8'h08, "R12 port", d, 8'h08);
    chk(sck_o == 0 && ss_n_o == 1 && !irq_done_o && !irq_fault_o && pin_oe_o == 0,
        "R12 pins", {sck_o, ss_n_o, irq_done_o, irq_fault_o, pin_oe_o}, 7'b0100000);

    // R1 register file
    wr(5'h04, 8'hFF); rd(5'h04, d); chk(d == 8'h77, "R1 baud", d, 8'h77);
    wr(5'h01, 8'hA5); rd(5'h01, d); chk(d == 8'hA5, "R1 aux", d, 8'hA5);
    wr(5'h10, 8'h0E); rd(5'h10, d); chk(d == 8'h0E, "R1 dir", d, 8'h0E);
    chk(pin_oe_o == 3'b111, "R1 oe", pin_oe_o, 7);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 6; i++) begin
      automatic logic [31:0] v = VEC[i];
      automatic bit cp = v[26], ph = v[25], lsb = v[24];
      automatic int half = (int'(v[22:20]) + 1) << v[18:16];
      wr(5'h00, {4'b1101, cp, ph, 1'b0, lsb});
      chk(sck_o == cp, "R4 idle", sck_o, cp);
      wr(5'h04, v[23:16]);
      slave_arm(cp, ph, lsb, v[7:0]);
      wr(5'h09, v[15:8]);
      wait_done(n);
      chk(n == 16 * half, "R3 timing", n, 16 * half);
      chk(cap == v[15:8], "R5 mosi order", cap, v[15:8]);
      mon = 0;
      rd(5'h05, d); chk(d == 8'h80, "R6 status", d, 8'h80);
      rd(5'h09, d); chk(d == v[7:0], "R2 rx byte", d, v[7:0]);
      chk(!irq_done_o, "R8 cleared", irq_done_o, 0);
    end

    // R11 disabled write starts nothing
    wr(5'h00, 8'h90);
    wr(5'h09, 8'h55);
    repeat (40) @(negedge clk);
    chk(!irq_done_o && sck_o == 0, "R11 no shift", {irq_done_o, sck_o}, 0);
    rd(5'h05, d); chk(d == 8'h00, "R11 no flag", d, 0);

    // R7 collision and R10 auto select
    wr(5'h00, 8'hD2); wr(5'h04, 8'h11);
    slave_arm(0, 0, 0, 8'h44);
    wr(5'h09, 8'h33);
    chk(ss_n_o == 0, "R10 auto low", ss_n_o, 0);
    repeat (10) @(negedge clk);
    wr(5'h09, 8'hCC);
    wait_done(n);
    chk(cap == 8'h33, "R7 byte kept", cap, 8'h33);
    chk(ss_n_o == 1, "R10 auto high", ss_n_o, 1);
    mon = 0;
    // R8 data read without status read clears nothing
    rd(5'h09, d); chk(d == 8'h44, "R7 rx", d, 8'h44);
    chk(irq_done_o, "R8 no clear", irq_done_o, 1);
    rd(5'h05, d); chk(d == 8'hC0, "R7 status", d, 8'hC0);
    rd(5'h09, d);
    rd(5'h05, d); chk(d == 8'h00, "R8 both cleared", d, 0);
    wr(5'h00, 8'hD0); wr(5'h0D, 8'h00);
    chk(ss_n_o == 0, "R10 port bit", ss_n_o, 0);
    wr(5'h0D, 8'h08);

    // R9 no fault when select is an output
    ss_n_i = 0;
    repeat (3) @(negedge clk);
    rd(5'h05, d); chk(d == 8'h00, "R9 output no fault", d, 0);

    // R9 fault when idle
    wr(5'h10, 8'h06);
    @(negedge clk);
    chk(irq_fault_o, "R9 irq", irq_fault_o, 1);
    rd(5'h00, d); chk(d == 8'h80, "R9 ctrl cleared", d, 8'h80);
    ss_n_i = 1;
    rd(5'h05, d); chk(d == 8'h10, "R9 status", d, 8'h10);
    rd(5'h09, d);
    chk(!irq_fault_o, "R8 fault cleared", irq_fault_o, 0);

    // R9 abort mid-shift
    wr(5'h00, 8'hD0);
    wr(5'h09, 8'hF0);
    repeat (10) @(negedge clk);
    ss_n_i = 0;
    repeat (2) @(negedge clk);
    ss_n_i = 1;
    chk(sck_o == 0, "R9 sck idle", sck_o, 0);
    repeat (100) @(negedge clk);
    rd(5'h05, d); chk(d == 8'h10, "R9 abort status", d, 8'h10);
    rd(5'h09, d);

    finish_run();
  end
endmodule